// File: doc/BRIEF.md
# MDIO PHY-Side Register Responder

This block is the target end of a two-wire management bus. A station drives a slow management clock and a shared, open data line. The block watches both, recognises management frames and serves a small register file. Each frame carries a start pattern, an opcode, a 5-bit device address and a 5-bit register address, then a two-bit turnaround and sixteen data bits. The block's device address is fixed at 10h by parameter. Frames for any other address pass by with the line left alone.

A preamble of ones is optional. The block can pick up a start pattern straight after idle, and it reports this ability in a fixed bit of its status register. For a read, it releases the line for the first turnaround bit and drives a zero in the second. It then shifts out the sixteen register bits, most significant first, and releases the line afterwards. A write lands in the register file only after the sixteenth data bit. A pulse on the register-file port reports each accepted write.

Both bus inputs are resynchronised to the system clock `clk`. The data line is sampled on each detected rising edge of the management clock. The driven value changes only after a detected falling edge.

Top module: `mdio_phy_responder`

## Requirements
- R1: After reset `mdio_oe` and `wr_stb` are 0, and every writable register reads 0000h.
- R2: For a read addressed to 10h, the first turnaround bit is left undriven. The second is driven 0. The 16 data bits follow, bit 15 first. The line is undriven in the bit period after the last data bit.
- R3: A write addressed to 10h with turnaround bits 1 then 0 stores its 16 data bits, MSB first, once the sixteenth bit has been sampled. It gives a one-cycle `wr_stb` with the register address on `wr_addr` and the value on `wr_data`, and a later read returns the value.
- R4: A frame whose device address is not 10h drives nothing during the frame and changes no register.
- R5: Frames are accepted both with a preamble of 32 ones and with no preamble at all, including back-to-back frames separated by a single idle bit.
- R6: Register 1 always reads 7849h: bit 6 is set to advertise preamble-free operation, and the other bits are fixed. Writes to it are discarded without a strobe.
- R7: Only registers 0 to 7 exist. Reads of registers 8 to 31 return 0000h, and writes to them are discarded without a strobe and without touching registers 0 to 7.
- R8: A frame whose opcode is neither 10 (read) nor 01 (write) drives nothing and changes no register.
- R9: A write whose turnaround bits are not 1 then 0 is abandoned: no register changes and no strobe.
- R10: A start pattern other than 0 then 1 is rejected. The block keeps hunting, and the next valid frame is served normally.
- R11: `mdio_oe` and `mdio_o` change only in the cycle after a detected falling edge of `mdc`, and they stay constant while `mdc` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Sensed level of the shared data line |
| mdio_o | output | 1 | Value the block drives onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line; 0 leaves it released |
| wr_stb | output | 1 | One-cycle pulse for each accepted register write |
| wr_addr | output | 5 | Register address of the accepted write |
| wr_data | output | 16 | Value stored by the accepted write |

## Verification
A new drive value appears three `clk` cycles after a falling edge of `mdc`: two synchroniser stages, then one output register. The write strobe follows a rising edge by four cycles: synchroniser, frame register, register-file register. The bench holds each `mdc` phase for eight system cycles. It samples the line and `mdio_oe` at the end of the low phase, well after the drive has settled. A second sample in the middle of the high phase must match the first. Strobes are counted by a monitor across the whole frame and compared once an idle bit has passed, so no check depends on the exact edge in which a result lands.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int MDIO_DW = 16;
    localparam int MDIO_AW = 5;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

    typedef enum logic [3:0] {
        S_HUNT,
        S_START,
        S_OPCODE,
        S_ADDR,
        S_RD_TA,
        S_RD_DATA,
        S_WR_TA,
        S_WR_DATA,
        S_SKIP
    } frame_state_e;
endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic rise_o,
    output logic fall_o,
    output logic mdio_s_o
);
    typedef struct packed {
        logic [STAGES-1:0] clk_pipe;
        logic [STAGES-1:0] dat_pipe;
        logic              clk_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.clk_pipe = {s_q.clk_pipe[STAGES-2:0], mdc_i};
        s_d.dat_pipe = {s_q.dat_pipe[STAGES-2:0], mdio_i};
        s_d.clk_prev = s_q.clk_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.clk_pipe <= '0;
            s_q.dat_pipe <= '1;
            s_q.clk_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o   = s_q.clk_pipe[STAGES-1] & ~s_q.clk_prev;
    assign fall_o   = ~s_q.clk_pipe[STAGES-1] & s_q.clk_prev;
    assign mdio_s_o = s_q.dat_pipe[STAGES-1];
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_pkg::*;
#(
    parameter int                 NREG        = 8,
    parameter int                 STATUS_IDX  = 1,
    parameter logic [MDIO_DW-1:0] STATUS_BITS = 16'h7809,
    parameter int                 NOPRE_BIT   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [MDIO_AW-1:0] wr_addr_i,
    input  logic [MDIO_DW-1:0] wr_data_i,
    input  logic [MDIO_AW-1:0] rd_addr_i,
    output logic [MDIO_DW-1:0] rd_data_o,
    output logic               stb_o,
    output logic [MDIO_AW-1:0] stb_addr_o,
    output logic [MDIO_DW-1:0] stb_data_o
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [MDIO_DW-1:0] STATUS_RD = STATUS_BITS | (MDIO_DW'(1) << NOPRE_BIT);

    typedef struct packed {
        logic               stb;
        logic [MDIO_AW-1:0] addr;
        logic [MDIO_DW-1:0] data;
    } stb_t;

    logic               wr_ok;
    logic [MDIO_DW-1:0] rd_vec [NREG];
    stb_t               st_d, st_q;

    assign wr_ok = wr_en_i && (int'(wr_addr_i) < NREG)
                && (wr_addr_i != MDIO_AW'(STATUS_IDX));

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == STATUS_IDX) begin : g_ro
            assign rd_vec[i] = STATUS_RD;
        end else begin : g_rw
            logic [MDIO_DW-1:0] r_d, r_q;
            always_comb begin
                r_d = r_q;
                if (wr_ok && wr_addr_i == MDIO_AW'(i)) r_d = wr_data_i;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= '0;
                else        r_q <= r_d;
            end
            assign rd_vec[i] = r_q;
        end
    end

    always_comb begin
        if (int'(rd_addr_i) < NREG) rd_data_o = rd_vec[rd_addr_i[IW-1:0]];
        else                        rd_data_o = '0;
    end

    always_comb begin
        st_d      = st_q;
        st_d.stb  = wr_ok;
        if (wr_ok) begin
            st_d.addr = wr_addr_i;
            st_d.data = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stb_o      = st_q.stb;
    assign stb_addr_o = st_q.addr;
    assign stb_data_o = st_q.data;
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_pkg::*;
#(
    parameter logic [MDIO_AW-1:0] PHY_ADDR = 5'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic               bit_i,
    input  logic [MDIO_DW-1:0] rd_data_i,
    output logic [MDIO_AW-1:0] rd_addr_o,
    output logic               wr_en_o,
    output logic [MDIO_AW-1:0] wr_addr_o,
    output logic [MDIO_DW-1:0] wr_data_o,
    output logic               mdio_o,
    output logic               mdio_oe_o
);
    localparam int CW        = 5;
    localparam int ADDR_BITS = 2 * MDIO_AW;
    localparam int SKIP_BITS = 2 + MDIO_DW;

    typedef struct packed {
        frame_state_e       state;
        logic [CW-1:0]      cnt;
        logic [MDIO_DW-1:0] sh;
        logic               is_rd;
        logic [MDIO_AW-1:0] regad;
        logic [MDIO_DW-1:0] tx;
        logic               wr_en;
        logic [MDIO_DW-1:0] wr_data;
        logic               o;
        logic               oe;
    } fr_t;

    fr_t f_d, f_q;
    logic [1:0]           op_bits;
    logic [ADDR_BITS-1:0] addr_bits;

    assign op_bits   = {f_q.sh[0], bit_i};
    assign addr_bits = {f_q.sh[ADDR_BITS-2:0], bit_i};

    always_comb begin
        f_d       = f_q;
        f_d.wr_en = 1'b0;
        if (rise_i) begin
            f_d.sh  = {f_q.sh[MDIO_DW-2:0], bit_i};
            f_d.cnt = f_q.cnt + 1'b1;
            unique case (f_q.state)
                S_HUNT:  if (!bit_i) f_d.state = S_START;
                S_START: begin
                    f_d.cnt   = '0;
                    f_d.state = bit_i ? S_OPCODE : S_HUNT;
                end
                S_OPCODE: if (f_q.cnt == CW'(1)) begin
                    f_d.cnt = '0;
                    if (op_bits == OP_READ) begin
                        f_d.is_rd = 1'b1;
                        f_d.state = S_ADDR;
                    end else if (op_bits == OP_WRITE) begin
                        f_d.is_rd = 1'b0;
                        f_d.state = S_ADDR;
                    end else begin
                        f_d.state = S_HUNT;
                    end
                end
                S_ADDR: if (f_q.cnt == CW'(ADDR_BITS - 1)) begin
                    f_d.cnt   = '0;
                    f_d.regad = addr_bits[MDIO_AW-1:0];
                    if (addr_bits[ADDR_BITS-1:MDIO_AW] != PHY_ADDR) f_d.state = S_SKIP;
                    else if (f_q.is_rd)                            f_d.state = S_RD_TA;
                    else                                           f_d.state = S_WR_TA;
                end
                S_RD_TA: if (f_q.cnt == CW'(1)) begin
                    f_d.cnt   = '0;
                    f_d.tx    = rd_data_i;
                    f_d.state = S_RD_DATA;
                end
                S_RD_DATA: if (f_q.cnt == CW'(MDIO_DW - 1)) f_d.state = S_HUNT;
                S_WR_TA: begin
                    if (f_q.cnt == '0) begin
                        if (!bit_i) f_d.state = S_HUNT;
                    end else begin
                        f_d.cnt   = '0;
                        f_d.state = bit_i ? S_HUNT : S_WR_DATA;
                    end
                end
                S_WR_DATA: if (f_q.cnt == CW'(MDIO_DW - 1)) begin
                    f_d.wr_en   = 1'b1;
                    f_d.wr_data = {f_q.sh[MDIO_DW-2:0], bit_i};
                    f_d.state   = S_HUNT;
                end
                S_SKIP: if (f_q.cnt == CW'(SKIP_BITS - 1)) f_d.state = S_HUNT;
                default: f_d.state = S_HUNT;
            endcase
        end else if (fall_i) begin
            if (f_q.state == S_RD_TA && f_q.cnt == CW'(1)) begin
                f_d.oe = 1'b1;
                f_d.o  = 1'b0;
            end else if (f_q.state == S_RD_DATA) begin
                f_d.oe = 1'b1;
                f_d.o  = f_q.tx[MDIO_DW-1];
                f_d.tx = {f_q.tx[MDIO_DW-2:0], 1'b0};
            end else begin
                f_d.oe = 1'b0;
                f_d.o  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q       <= '0;
            f_q.state <= S_HUNT;
        end else begin
            f_q <= f_d;
        end
    end

    assign rd_addr_o = f_q.regad;
    assign wr_en_o   = f_q.wr_en;
    assign wr_addr_o = f_q.regad;
    assign wr_data_o = f_q.wr_data;
    assign mdio_o    = f_q.o;
    assign mdio_oe_o = f_q.oe;
endmodule

// File: rtl/mdio_phy_responder.sv
module mdio_phy_responder
    import mdio_pkg::*;
#(
    parameter logic [MDIO_AW-1:0] PHY_ADDR    = 5'h10,
    parameter int                 NREG        = 8,
    parameter logic [MDIO_DW-1:0] STATUS_BITS = 16'h7809,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mdc,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               wr_stb,
    output logic [MDIO_AW-1:0] wr_addr,
    output logic [MDIO_DW-1:0] wr_data
);
    logic               mdc_rise, mdc_fall, mdio_s;
    logic [MDIO_AW-1:0] rf_rd_addr, rf_wr_addr;
    logic [MDIO_DW-1:0] rf_rd_data, rf_wr_data;
    logic               rf_wr_en;

    mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc_i    (mdc),
        .mdio_i   (mdio_i),
        .rise_o   (mdc_rise),
        .fall_o   (mdc_fall),
        .mdio_s_o (mdio_s)
    );

    mdio_frame_ctrl #(.PHY_ADDR(PHY_ADDR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (mdc_rise),
        .fall_i    (mdc_fall),
        .bit_i     (mdio_s),
        .rd_data_i (rf_rd_data),
        .rd_addr_o (rf_rd_addr),
        .wr_en_o   (rf_wr_en),
        .wr_addr_o (rf_wr_addr),
        .wr_data_o (rf_wr_data),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe)
    );

    mdio_regfile #(.NREG(NREG), .STATUS_BITS(STATUS_BITS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (rf_wr_en),
        .wr_addr_i  (rf_wr_addr),
        .wr_data_i  (rf_wr_data),
        .rd_addr_i  (rf_rd_addr),
        .rd_data_o  (rf_rd_data),
        .stb_o      (wr_stb),
        .stb_addr_o (wr_addr),
        .stb_data_o (wr_data)
    );
endmodule

// File: rtl/mdio_phy_responder_chk.sv
module mdio_phy_responder_chk #(
    parameter int NREG = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mdc_fall,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic       wr_stb,
    input logic [4:0] wr_addr
);
    AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe != $past(mdio_oe)) |-> $past(mdc_fall)); // R11

    AST_DATA_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_o != $past(mdio_o)) |-> $past(mdc_fall)); // R11

    AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o); // R2

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R3

    AST_STB_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ((int'(wr_addr) < NREG) && (wr_addr != 5'd1))); // R7
endmodule

bind mdio_phy_responder mdio_phy_responder_chk #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc_fall (mdc_fall),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr)
);

// File: tb/sim_mdio_phy_responder.sv
module sim_mdio_phy_responder;
    typedef struct packed {
        logic        pre;
        logic [1:0]  st;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  ra;
        logic [1:0]  ta;
        logic [15:0] data;
        logic        drv;
        logic [15:0] exp;
        logic        stb;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam logic [15:0] STATUS = 16'h7849;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'b01, 2'b10, 5'h10, 5'd0, 2'b11, 16'hFFFF, 1'b1, 16'h0000, 1'b0, 8'd1},  // R1
        '{1'b0, 2'b01, 2'b01, 5'h10, 5'd0, 2'b10, 16'hA5C3, 1'b0, 16'h0000, 1'b1, 8'd3},  // R3
        '{1'b0, 2'b01, 2'b10, 5'h10, 5'd0, 2'b11, 16'hFFFF, 1'b1, 16'hA5C3, 1'b0, 8'd2},  // R2
        '{1'b1, 2'b01, 2'b01, 5'h10, 5'd3, 2'b10, 16'h1234, 1'b0, 16'h0000, 1'b1, 8'd5},  // R5
        '{1'b0, 2'b01, 2'b10, 5'h10, 5'd3, 2'b11, 16'hFFFF, 1'b1, 16'h1234, 1'b0, 8'd5},  // R5
        '{1'b0, 2'b01, 2'b10, 5'h10, 5'd1, 2'b11, 16'hFFFF, 1'b1, STATUS,   1'b0, 8'd6},  // R6
        '{1'b0, 2'b01, 2'b01, 5'h10, 5'd1, 2'b10, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 8'd6},  // R6
        '{1'b0, 2'b01, 2'b10, 5'h10, 5'd1, 2'b11, 16'hFFFF, 1'b1, STATUS,   1'b0, 8'd6},  // R6
        '{1'b0, 2'b01, 2'b01, 5'h03, 5'd0, 2'b10, 16'h0000, 1'b0, 16'h0000, 1'b0, 8'd4},  // R4
        '{1'b0, 2'b01, 2'b10, 5'h10, 5'd0, 2'b11, 16'hFFFF, 1'b1, 16'hA5C3, 1'b0, 8'd4},  // R4
        '{1'b0, 2'b01, 2'b10, 5'h11, 5'd0, 2'b11, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 8'd4},  // R4
        '{1'b0, 2'b01, 2'b01, 5'h10, 5'd8, 2'b10, 16'hBEEF, 1'b0, 16'h0000, 1'b0, 8'd7},  // R7
        '{1'b0, 2'b01, 2'b10, 5'h10, 5'd8, 2'b11, 16'hFFFF, 1'b1, 16'h0000, 1'b0, 8'd7},  // R7
        '{1'b0, 2'b01, 2'b11, 5'h1F, 5'h1F, 2'b11, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 8'd8}, // R8
        '{1'b0, 2'b01, 2'b00, 5'h1F, 5'h1F, 2'b11, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 8'd8}, // R8
        '{1'b0, 2'b01, 2'b01, 5'h10, 5'd0, 2'b11, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 8'd9},  // R9
        '{1'b0, 2'b01, 2'b10, 5'h10, 5'd0, 2'b11, 16'hFFFF, 1'b1, 16'hA5C3, 1'b0, 8'd9},  // R9
        '{1'b0, 2'b00, 2'b11, 5'h1F, 5'h1F, 2'b11, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 8'd10}, // R10
        '{1'b0, 2'b01, 2'b10, 5'h10, 5'd3, 2'b11, 16'hFFFF, 1'b1, 16'h1234, 1'b0, 8'd10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic        st_en = 1'b0;
    logic        st_val = 1'b1;
    logic        line;
    logic        mdio_o, mdio_oe, wr_stb;
    logic [4:0]  wr_addr;
    logic [15:0] wr_data;

    int n_run = 0;
    int n_fail = 0;
    int stb_cnt = 0;
    logic [4:0]  stb_a = '0;
    logic [15:0] stb_d = '0;
    logic any_oe, contend, unstable;

    always #10 clk = ~clk;

    assign line = mdio_oe ? mdio_o : (st_en ? st_val : 1'b1);

    mdio_phy_responder u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .mdio_i  (line),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    always @(posedge clk) begin
        if (rst_n && wr_stb) begin
            stb_cnt <= stb_cnt + 1;
            stb_a   <= wr_addr;
            stb_d   <= wr_data;
        end
    end

    function automatic string req_name(input int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic slot(input logic en, input logic val, output logic seen, output logic oe_lo);
        logic o_lo;
        mdc = 1'b0; st_en = en; st_val = val;
        repeat (8) @(negedge clk);
        seen = line; oe_lo = mdio_oe; o_lo = mdio_o;
        if (mdio_oe) any_oe = 1'b1;
        if (mdio_oe && en) contend = 1'b1;
        mdc = 1'b1;
        repeat (6) @(negedge clk);
        if (mdio_oe !== oe_lo || mdio_o !== o_lo) unstable = 1'b1;
        if (mdio_oe) any_oe = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_frame(input vec_t v, output logic ta1_oe, output logic ta2_oe,
                             output logic ta2_v, output logic [15:0] rdata, output logic post_oe);
        logic s, e, rd;
        logic [13:0] hdr;
        any_oe = 1'b0; contend = 1'b0; unstable = 1'b0;
        rd = (v.st == 2'b01) && (v.op == 2'b10);
        hdr = {v.st, v.op, v.phy, v.ra};
        if (v.pre) for (int i = 0; i < 32; i++) slot(1'b1, 1'b1, s, e);
        for (int i = 13; i >= 0; i--) slot(1'b1, hdr[i], s, e);
        slot(!rd, v.ta[1], s, ta1_oe);
        slot(!rd, v.ta[0], ta2_v, ta2_oe);
        for (int i = 15; i >= 0; i--) begin
            slot(!rd, v.data[i], s, e);
            rdata[i] = s;
        end
        slot(1'b0, 1'b1, s, post_oe);
    endtask

    task automatic apply(input vec_t v, input string req);
        logic t1, t2, t2v, po;
        logic [15:0] rd;
        int sc0;
        sc0 = stb_cnt;
        run_frame(v, t1, t2, t2v, rd, po);
        check(!contend, req, "bus contention", 32'(contend), 32'd0);
        check(stb_cnt - sc0 == int'(v.stb), req, "write strobe count",
              32'(stb_cnt - sc0), 32'(v.stb));
        if (v.stb) begin
            check(stb_a == v.ra, req, "strobe address", 32'(stb_a), 32'(v.ra));
            check(stb_d == v.data, req, "strobe data", 32'(stb_d), 32'(v.data));
        end
        if (v.drv) begin
            check(!t1, "R2", "first turnaround bit released", 32'(t1), 32'd0);
            check(t2 && !t2v, "R2", "second turnaround bit driven 0",
                  {30'd0, t2, t2v}, 32'h2);
            check(rd == v.exp, req, "read data", 32'(rd), 32'(v.exp));
            check(!po, "R2", "line released after data", 32'(po), 32'd0);
            check(!unstable, "R11", "drive steady while mdc high", 32'(unstable), 32'd0);
        end else begin
            check(!any_oe, req, "no drive during frame", 32'(any_oe), 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog expired: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        vec_t w;
        repeat (4) @(negedge clk);
        check(mdio_oe == 1'b0, "R1", "oe in reset", 32'(mdio_oe), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(mdio_oe == 1'b0 && wr_stb == 1'b0, "R1", "outputs after reset",
              {30'd0, mdio_oe, wr_stb}, 32'd0);

        for (int k = 0; k < NV; k++) apply(VEC[k], req_name(int'(VEC[k].req)));

        // R1: reset in mid-run clears a written register
        w = '{1'b0, 2'b01, 2'b01, 5'h10, 5'd2, 2'b10, 16'h5A5A, 1'b0, 16'h0000, 1'b1, 8'd1};
        apply(w, "R3");
        w = '{1'b0, 2'b01, 2'b10, 5'h10, 5'd2, 2'b11, 16'hFFFF, 1'b1, 16'h5A5A, 1'b0, 8'd3};
        apply(w, "R3");
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(mdio_oe == 1'b0 && wr_stb == 1'b0, "R1", "outputs in mid-run reset",
              {30'd0, mdio_oe, wr_stb}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        w = '{1'b0, 2'b01, 2'b10, 5'h10, 5'd2, 2'b11, 16'hFFFF, 1'b1, 16'h0000, 1'b0, 8'd1};
        apply(w, "R1");
        // R7: write to register 15 must not alias onto register 7
        w = '{1'b0, 2'b01, 2'b01, 5'h10, 5'd15, 2'b10, 16'hCAFE, 1'b0, 16'h0000, 1'b0, 8'd7};
        apply(w, "R7");
        w = '{1'b0, 2'b01, 2'b10, 5'h10, 5'd7, 2'b11, 16'hFFFF, 1'b1, 16'h0000, 1'b0, 8'd7};
        apply(w, "R7");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule